// File: doc/BRIEF.md
# Synchronous Transmit Byte Feed

This block sits on the transmit side of a byte-oriented synchronous serial adapter, between the processor's data writes and the bit shifter. The processor pushes bytes into a three-entry FIFO. Each time the shifter reaches a word boundary it raises a one-cycle request. In that same cycle the block presents the byte to load. Normally this is the oldest queued byte, which is popped at the clock edge. When the queue is empty, the block supplies a filler byte instead: the sync code if sync filling is enabled, or all ones if it is not. A sync fill raises an underflow pulse and latches an underflow status flag.

A transmit-available status flag tells the processor whether the free space in the queue has reached a threshold. The threshold is one or two slots, chosen by a mode bit. Raising the transmit-hold input empties the queue, clears the underflow and clear-to-send flags, and stops the queue from being popped. While hold is high, the available flag reads as zero, but writes are still taken so the queue can be preloaded. Separate write strobes clear the two status flags. The clear bits do not persist.

Top module: `stx_feed`

## Requirements
- R1: After synchronous reset, `level` is 0, `st_avail` is 1, `st_uf` and `st_cts` are 0, the threshold is two slots and sync filling is off.
- R2: The queue holds at most 3 bytes. A `push_en` that arrives when `level` is 3 is dropped, and `level` and the queued bytes are unchanged.
- R3: When `req` is high, hold is low and the queue is not empty, `req_byte` shows the oldest byte in that cycle, `uf_pulse` is low, and the byte is removed at the clock edge.
- R4: When `req` is high, hold is low, the queue is empty and sync filling is on (`mode_sync_fill`=1 at the last mode write), `req_byte` equals `sync_code` and `uf_pulse` is 1 in that cycle. `st_uf` is 1 from the next cycle on.
- R5: When `req` is high, hold is low, the queue is empty and sync filling is off, `req_byte` is 8'hFF, `uf_pulse` is 0 and `st_uf` is unchanged.
- R6: When `req` is high while `tx_hold` is 1, `req_byte` is 8'hFF, `uf_pulse` is 0 and `level` does not drop.
- R7: In the first cycle that `tx_hold` is 1 after being 0, the queue is emptied, `st_uf` and `st_cts` are cleared, and that cycle's push and `cts_evt` are ignored.
- R8: While `tx_hold` is 0, `st_avail` is 1 exactly when 3 − `level` is at least the threshold. The threshold is 1 slot when `mode_thr_one`=1 and 2 slots when it is 0. A mode write re-evaluates the flag from the next cycle.
- R9: While `tx_hold` is 1, `st_avail` reads 0. Pushes are still accepted, and the flag reflects them once hold is released.
- R10: A `flag_wr` with `flag_clr_uf`=1 clears `st_uf`, and a `flag_wr` with `flag_clr_cts`=1 clears `st_cts`. Neither clear bit affects the other flag or persists, so later events set the flag again.
- R11: `cts_evt` sets `st_cts` at the next edge. A set event and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | 1 | Write one byte into the queue |
| push_data | input | 8 | Byte to queue |
| mode_wr | input | 1 | Load the mode bits |
| mode_thr_one | input | 1 | 1: one-slot threshold, 0: two-slot threshold |
| mode_sync_fill | input | 1 | 1: fill an underflow with the sync code |
| flag_wr | input | 1 | Status clear strobe |
| flag_clr_uf | input | 1 | Clear underflow status with `flag_wr` |
| flag_clr_cts | input | 1 | Clear clear-to-send status with `flag_wr` |
| tx_hold | input | 1 | Transmitter hold (reset) level |
| cts_evt | input | 1 | Clear-to-send change event, sets `st_cts` |
| sync_code | input | 8 | Sync character used as filler |
| req | input | 1 | Shifter next-byte request strobe |
| req_byte | output | 8 | Byte for the shifter, valid in the `req` cycle |
| uf_pulse | output | 1 | One-cycle underflow pulse with `req` |
| st_avail | output | 1 | Transmit space available (masked in hold) |
| st_uf | output | 1 | Underflow status |
| st_cts | output | 1 | Clear-to-send status |
| level | output | 2 | Queue occupancy |

## Verification
A read or write pointer that slips shows at the ports on the next request, as a byte out of order. A stale occupancy count shows up in one of two ways: a dropped push that should have landed, or a filler byte where queued data was expected. The available flag is a register driven by events rather than a decode of the count. A missed update to it therefore shows one cycle after the push, pop or mode write as a mismatch against 3 − `level` and the threshold. The bench sweeps every fill depth, both thresholds and both fill modes, and compares every output each cycle, so such faults appear within one or two cycles of the step that exposes them.

// File: rtl/stx_pkg.sv
package stx_pkg;

    parameter int STX_W = 8;

    typedef enum logic [1:0] {
        SRC_QUEUE = 2'd0,
        SRC_SYNC  = 2'd1,
        SRC_ONES  = 2'd2
    } src_e;

    typedef struct packed {
        src_e src;
        logic pop;
        logic uf;
    } fetch_t;

    function automatic fetch_t stx_decide(input logic req, input logic hold,
                                          input logic empty, input logic sync_on);
        fetch_t f;
        f.src = SRC_ONES;
        f.pop = 1'b0;
        f.uf  = 1'b0;
        if (!hold) begin
            if (!empty) begin
                f.src = SRC_QUEUE;
                f.pop = req;
            end else if (sync_on) begin
                f.src = SRC_SYNC;
                f.uf  = req;
            end
        end
        return f;
    endfunction

    function automatic logic stx_meets(input int free_slots, input logic one, input int hi);
        return free_slots >= (one ? 1 : hi);
    endfunction

endpackage

// File: rtl/stx_store.sv
module stx_store #(
    parameter int W     = 8,
    parameter int DEPTH = 3,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt
);

    logic [W-1:0]  slot [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic          accept;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign accept = push && (count != CW'(DEPTH)) && !flush;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (accept && (wr_ptr == PW'(i)))
                    slot[i] <= wdata;
            end
        end
    endgenerate

    always_comb begin
        if (flush)
            count_nxt = '0;
        else
            case ({accept, pop})
                2'b10:   count_nxt = count + CW'(1);
                2'b01:   count_nxt = count - CW'(1);
                default: count_nxt = count;
            endcase
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= step(wr_ptr);
            if (pop)    rd_ptr <= step(rd_ptr);
            count <= count_nxt;
        end
    end

    assign head = slot[rd_ptr];

endmodule

// File: rtl/stx_avail.sv
module stx_avail
    import stx_pkg::*;
#(
    parameter int DEPTH  = 3,
    parameter int THR_HI = 2,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          mode_wr,
    input  logic          thr_one_new,
    input  logic          thr_one_cur,
    input  logic          push,
    input  logic          pop,
    input  logic [CW-1:0] count_nxt,
    output logic          avail
);

    logic thr_sel;
    logic meets;

    assign thr_sel = mode_wr ? thr_one_new : thr_one_cur;
    assign meets   = stx_meets(DEPTH - int'(count_nxt), thr_sel, THR_HI);

    always_ff @(posedge clk) begin
        if (rst || flush)
            avail <= 1'b1;
        else if (mode_wr)
            avail <= meets;
        else if (pop && meets)
            avail <= 1'b1;
        else if (push && !meets)
            avail <= 1'b0;
    end

endmodule

// File: rtl/stx_flags.sv
module stx_flags (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic uf_set,
    input  logic uf_clr,
    input  logic cts_set,
    input  logic cts_clr,
    output logic uf,
    output logic cts
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            uf  <= 1'b0;
            cts <= 1'b0;
        end else begin
            if (uf_set)       uf <= 1'b1;
            else if (uf_clr)  uf <= 1'b0;
            if (cts_set)      cts <= 1'b1;
            else if (cts_clr) cts <= 1'b0;
        end
    end

endmodule

// File: rtl/stx_feed.sv
module stx_feed
    import stx_pkg::*;
#(
    parameter int W      = STX_W,
    parameter int DEPTH  = 3,
    parameter int THR_HI = 2,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_en,
    input  logic [W-1:0]  push_data,
    input  logic          mode_wr,
    input  logic          mode_thr_one,
    input  logic          mode_sync_fill,
    input  logic          flag_wr,
    input  logic          flag_clr_uf,
    input  logic          flag_clr_cts,
    input  logic          tx_hold,
    input  logic          cts_evt,
    input  logic [W-1:0]  sync_code,
    input  logic          req,
    output logic [W-1:0]  req_byte,
    output logic          uf_pulse,
    output logic          st_avail,
    output logic          st_uf,
    output logic          st_cts,
    output logic [CW-1:0] level
);

    logic          thr_one_q, sync_fill_q, hold_q;
    logic          flush;
    logic [W-1:0]  head;
    logic [CW-1:0] count, count_nxt;
    logic          avail_raw;
    fetch_t        fetch;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_one_q   <= 1'b0;
            sync_fill_q <= 1'b0;
            hold_q      <= 1'b0;
        end else begin
            hold_q <= tx_hold;
            if (mode_wr) begin
                thr_one_q   <= mode_thr_one;
                sync_fill_q <= mode_sync_fill;
            end
        end
    end

    assign flush = tx_hold && !hold_q;
    assign fetch = stx_decide(req, tx_hold, count == '0, sync_fill_q);

    stx_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .flush(flush),
        .push(push_en), .pop(fetch.pop), .wdata(push_data),
        .head(head), .count(count), .count_nxt(count_nxt)
    );

    stx_avail #(.DEPTH(DEPTH), .THR_HI(THR_HI)) u_avail (
        .clk(clk), .rst(rst), .flush(flush),
        .mode_wr(mode_wr), .thr_one_new(mode_thr_one), .thr_one_cur(thr_one_q),
        .push(push_en), .pop(fetch.pop), .count_nxt(count_nxt),
        .avail(avail_raw)
    );

    stx_flags u_flags (
        .clk(clk), .rst(rst), .flush(flush),
        .uf_set(fetch.uf), .uf_clr(flag_wr && flag_clr_uf),
        .cts_set(cts_evt), .cts_clr(flag_wr && flag_clr_cts),
        .uf(st_uf), .cts(st_cts)
    );

    always_comb begin
        case (fetch.src)
            SRC_QUEUE: req_byte = head;
            SRC_SYNC:  req_byte = sync_code;
            default:   req_byte = '1;
        endcase
    end

    assign uf_pulse = fetch.uf;
    assign st_avail = avail_raw && !tx_hold;
    assign level    = count;

endmodule

// File: rtl/stx_chk.sv
module stx_chk #(
    parameter int W     = 8,
    parameter int DEPTH = 3,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          push_en,
    input logic          tx_hold,
    input logic          cts_evt,
    input logic          req,
    input logic [W-1:0]  req_byte,
    input logic          uf_pulse,
    input logic          st_avail,
    input logic          st_uf,
    input logic          st_cts,
    input logic [CW-1:0] level
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH)); // R2

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push_en && !req && !tx_hold && level == CW'(DEPTH)) |=> level == CW'(DEPTH)); // R2

    AST_POP_ONE: assert property (@(posedge clk) disable iff (rst)
        (req && !tx_hold && !push_en && level != '0) |=> level == $past(level) - CW'(1)); // R3

    AST_UF_LATCH: assert property (@(posedge clk) disable iff (rst)
        (uf_pulse && !tx_hold) |=> st_uf); // R4

    AST_UF_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        uf_pulse |-> (req && level == '0)); // R4

    AST_HOLD_ONES: assert property (@(posedge clk) disable iff (rst)
        (req && tx_hold) |-> (req_byte == '1 && !uf_pulse)); // R6

    AST_HOLD_FLUSH: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_hold) |=> (level == '0 && !st_uf && !st_cts)); // R7

    AST_AVAIL_MASK: assert property (@(posedge clk) disable iff (rst)
        tx_hold |-> !st_avail); // R9

    AST_CTS_SET: assert property (@(posedge clk) disable iff (rst)
        (cts_evt && !tx_hold) |=> st_cts); // R11

endmodule

bind stx_feed stx_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .push_en(push_en), .tx_hold(tx_hold), .cts_evt(cts_evt),
    .req(req), .req_byte(req_byte), .uf_pulse(uf_pulse), .st_avail(st_avail),
    .st_uf(st_uf), .st_cts(st_cts), .level(level)
);

// File: tb/sim_stx_feed.sv
module sim_stx_feed;

    logic       clk = 1'b0;
    logic       rst;
    logic       push_en, mode_wr, mode_thr_one, mode_sync_fill;
    logic       flag_wr, flag_clr_uf, flag_clr_cts, tx_hold, cts_evt, req;
    logic [7:0] push_data, sync_code, req_byte;
    logic       uf_pulse, st_avail, st_uf, st_cts;
    logic [1:0] level;

    always #2.5 clk = ~clk;

    stx_feed u0 (
        .clk(clk), .rst(rst), .push_en(push_en), .push_data(push_data),
        .mode_wr(mode_wr), .mode_thr_one(mode_thr_one), .mode_sync_fill(mode_sync_fill),
        .flag_wr(flag_wr), .flag_clr_uf(flag_clr_uf), .flag_clr_cts(flag_clr_cts),
        .tx_hold(tx_hold), .cts_evt(cts_evt), .sync_code(sync_code), .req(req),
        .req_byte(req_byte), .uf_pulse(uf_pulse), .st_avail(st_avail),
        .st_uf(st_uf), .st_cts(st_cts), .level(level)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    int       m_cnt;
    logic [7:0] m_q [3];
    logic     m_thr_one, m_sync, m_uf, m_cts, m_hold;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check combinational outputs, then registered ones.
    task automatic cyc(input logic p, input logic [7:0] pd, input logic rq,
                       input logic mw, input logic mt, input logic ms,
                       input logic fw, input logic cu, input logic cc,
                       input logic h, input logic ce);
        logic [7:0] eb;
        logic       ep, flush;
        int         cnt0;
        @(negedge clk);
        push_en = p; push_data = pd; req = rq; mode_wr = mw; mode_thr_one = mt;
        mode_sync_fill = ms; flag_wr = fw; flag_clr_uf = cu; flag_clr_cts = cc;
        tx_hold = h; cts_evt = ce;
        #1;
        ep = rq && !h && m_cnt == 0 && m_sync;
        if (rq) begin
            if (h) begin
                eb = 8'hFF;
                chk(req_byte == eb, "R6 hold byte", int'(req_byte), int'(eb));
            end else if (m_cnt > 0) begin
                eb = m_q[0];
                chk(req_byte == eb, "R3 oldest byte", int'(req_byte), int'(eb));
            end else if (m_sync) begin
                eb = sync_code;
                chk(req_byte == eb, "R4 sync fill", int'(req_byte), int'(eb));
            end else begin
                eb = 8'hFF;
                chk(req_byte == eb, "R5 ones fill", int'(req_byte), int'(eb));
            end
        end
        chk(uf_pulse == ep, "R4 R5 R6 uf_pulse", int'(uf_pulse), int'(ep));
        @(posedge clk);
        #1;
        flush = h && !m_hold;
        cnt0  = m_cnt;
        if (flush) begin
            m_cnt = 0; m_uf = 0; m_cts = 0;
        end else begin
            if (rq && !h && cnt0 > 0) begin
                m_q[0] = m_q[1]; m_q[1] = m_q[2];
                m_cnt--;
            end
            if (p && cnt0 < 3) begin
                m_q[m_cnt] = pd;
                m_cnt++;
            end
            if (ep) m_uf = 1;
            else if (fw && cu) m_uf = 0;
            if (ce) m_cts = 1;
            else if (fw && cc) m_cts = 0;
        end
        if (mw) begin m_thr_one = mt; m_sync = ms; end
        m_hold = h;
        chk(level == 2'(m_cnt), "R2 R3 R7 level", int'(level), m_cnt);
        chk(st_avail == (!h && (3 - m_cnt) >= (m_thr_one ? 1 : 2)),
            "R8 R9 st_avail", int'(st_avail), int'(!h && (3 - m_cnt) >= (m_thr_one ? 1 : 2)));
        chk(st_uf == m_uf, "R4 R7 R10 st_uf", int'(st_uf), int'(m_uf));
        chk(st_cts == m_cts, "R7 R10 R11 st_cts", int'(st_cts), int'(m_cts));
    endtask

    task automatic idle();
        cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic push(input logic [7:0] d);
        cyc(1, d, 0, 0, 0, 0, 0, 0, 0, m_hold, 0);
    endtask

    task automatic pull();
        cyc(0, 8'h00, 1, 0, 0, 0, 0, 0, 0, m_hold, 0);
    endtask

    initial begin
        rst = 1; push_en = 0; push_data = 0; req = 0; mode_wr = 0; mode_thr_one = 0;
        mode_sync_fill = 0; flag_wr = 0; flag_clr_uf = 0; flag_clr_cts = 0;
        tx_hold = 0; cts_evt = 0; sync_code = 8'h7E;
        m_cnt = 0; m_thr_one = 0; m_sync = 0; m_uf = 0; m_cts = 0; m_hold = 0;
        m_q[0] = 0; m_q[1] = 0; m_q[2] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1 reset state
        chk(level == 2'd0, "R1 level", int'(level), 0);
        chk(st_avail == 1'b1, "R1 st_avail", int'(st_avail), 1);
        chk(st_uf == 1'b0, "R1 st_uf", int'(st_uf), 0);
        chk(st_cts == 1'b0, "R1 st_cts", int'(st_cts), 0);
        pull(); // R1/R5: sync fill off after reset

        // Sweep thresholds, fill modes and fill depths (R2 R3 R4 R5 R8)
        for (int t = 0; t < 2; t++) begin
            for (int s = 0; s < 2; s++) begin
                sync_code = 8'h40 + 8'(t * 2 + s);
                cyc(0, 8'h00, 0, 1, 1'(t), 1'(s), 0, 0, 0, 0, 0);
                for (int n = 0; n <= 4; n++) begin
                    for (int k = 0; k < n; k++) push(8'(16 * n + k + 64 * t + 128 * s));
                    for (int k = 0; k <= n; k++) pull();
                    cyc(0, 8'h00, 0, 0, 0, 0, 1, 1, 0, 0, 0); // R10 clear uf
                end
            end
        end

        // Push and pull in the same cycle, partial and full (R2 R3)
        cyc(0, 8'h00, 0, 1, 0, 1, 0, 0, 0, 0, 0);
        push(8'hA1); push(8'hA2);
        cyc(1, 8'hA3, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        push(8'hA4);
        cyc(1, 8'hA5, 1, 0, 0, 0, 0, 0, 0, 0, 0); // full: push dropped
        repeat (3) pull();

        // Hold: flush, masking, preload (R6 R7 R9)
        push(8'hB1); push(8'hB2);
        cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 1);     // R11 cts set
        pull(); pull(); pull();                          // underflow -> st_uf
        push(8'hB3);
        cyc(1, 8'hB4, 0, 0, 0, 0, 0, 0, 0, 1, 1);     // R7 flush ignores push and cts
        pull();                                          // R6
        push(8'hC1); push(8'hC2); push(8'hC3); push(8'hC4);
        pull();                                          // R6 no pop
        cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0);     // R9 release, avail 0 at full
        pull(); pull(); pull(); pull();

        // Threshold re-evaluation at level 2 (R8)
        push(8'hD1); push(8'hD2);
        cyc(0, 8'h00, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        cyc(0, 8'h00, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 8'h00, 0, 1, 1, 1, 0, 0, 0, 0, 0);
        pull(); pull();

        // Flag clears and set priority (R10 R11)
        cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        pull();
        cyc(0, 8'h00, 0, 0, 0, 0, 1, 1, 0, 0, 0);     // R10 clear uf only
        cyc(0, 8'h00, 1, 0, 0, 0, 1, 1, 1, 0, 1);     // R11 set wins over clear
        cyc(0, 8'h00, 0, 0, 0, 0, 1, 1, 1, 0, 0);
        cyc(0, 8'h00, 0, 0, 0, 0, 1, 0, 0, 0, 1);     // R10 clear bits do not persist
        idle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1..: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule